// File: doc/BRIEF.md
# Quasi-linear interpolating sine synthesizer

This block is a direct digital frequency synthesizer that needs no sine lookup table. A 32-bit phase register is advanced on every enabled clock by a tuning word and wraps modulo 2^32. The output frequency is therefore tuning × f_clk / 2^32, which gives a step of about 0.023 Hz at a 100 MHz clock. The two top phase bits fold the phase into the first quarter wave. Bit 30 mirrors the phase and bit 31 negates the result. The next 14 bits of the phase are the folded index.

The folded index is split into eight equal segments. Each segment holds its own constants c0, c1 and c2, and the magnitude is evaluated as c0 + c1·t + c2·t², where t is the 11-bit offset inside the segment read as a fraction. The first segment uses only the straight-line term. The others add the squared term. The square comes from one multiplier. Every coefficient product is a constant shift-add network, and the segment bits pick the result through a multiplexer.

A three-stage pipeline (fold, products, sum) follows the phase register. The final stage clamps the magnitude to 32767 and restores the sign, so the output is a 16-bit two's complement sample qualified by a valid flag.

Top module: `qlin_ddfs`

## Requirements
- R1: After reset the phase is 0. Each rising edge with `en_i` high adds `tune_i` to the phase modulo 2^32. An edge with `en_i` low leaves the phase unchanged.
- R2: The phase value held before an edge at which `en_i` is high produces a sample on `sample_o`. That sample appears with `valid_o` high right after the third rising edge, counting that edge as the first. After an edge with `en_i` low, `valid_o` is low right after the third edge, again counting that edge as the first.
- R3: While `rst_n` is low, `valid_o` and `sample_o` are 0 and the pipeline is cleared. After release with `en_i` low, `valid_o` stays 0.
- R4: Every valid sample is within 48 LSB of 32767·sin(2π·P/2^32), where P is the phase that produced it.
- R5: Two phases that differ only in bit 31 give samples that are exact two's complement negatives of each other.
- R6: Let k be phase bits 29:16. A phase with bits 31:30 = 01 and index k gives exactly the same sample as a phase with bits 31:30 = 00 and index ~k (bitwise inverse).
- R7: Phase bits 15:0 have no effect on the sample.
- R8: A valid sample is never -32768. Phase 0 gives exactly 0. Phases 0x4000_0000 and 0xC000_0000 give magnitudes between 32719 and 32767.
- R9: While `valid_o` is low, `sample_o` keeps the last value it held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance the phase and launch a sample this cycle |
| tune_i | input | 32 | Phase increment per enabled clock |
| sample_o | output | 16 | Signed sine sample, two's complement |
| valid_o | output | 1 | High for the cycle in which `sample_o` carries a new sample |

## Verification
Several tuning words are streamed and every sample is compared with a real-valued sine of the phase tracked in the bench:
- A power-of-two step exposes the same small set of phases every period, which exposes a wrong segment or a wrong quadrant.
- An irregular word sweeps every segment offset, which exposes coefficient errors inside the segments.
- A word just short of a full turn wraps on every step, which tests the modulo behaviour.

Single phases are loaded by pulsing one large tuning word and then holding a zero word. These phases sit at each segment edge, at the quadrant peaks and at mirrored or negated pairs. They separate folding and sign faults, which break exact equalities, from fit errors, which only break the error bound. A pattern that switches the enable and then pauses it tells a latency fault from a fault where the phase keeps running while the enable is low.

// File: rtl/qlin_ddfs_pkg.sv
package qlin_ddfs_pkg;

  localparam int SEG_BITS = 3;
  localparam int COEF_W   = 16;
  localparam int OPND_W   = 24;
  localparam int PROD_W   = 40;
  localparam int TERM_W   = 20;

  typedef struct packed {
    logic signed [COEF_W-1:0] c0;
    logic signed [COEF_W-1:0] c1;
    logic signed [COEF_W-1:0] c2;
  } seg_coef_t;

  // Three-point fit per segment, in output LSB, with t = offset / 2^OFF_W.
  // Segment 0 is evaluated as a straight line only.
  function automatic seg_coef_t seg_coef(input logic [SEG_BITS-1:0] s);
    seg_coef_t r;
    case (s)
      3'd0:    r = '{c0: 16'sd0,     c1: 16'sd6392, c2: 16'sd0};
      3'd1:    r = '{c0: 16'sd6393,  c1: 16'sd6330, c2: -16'sd183};
      3'd2:    r = '{c0: 16'sd12539, c1: 16'sd5963, c2: -16'sd298};
      3'd3:    r = '{c0: 16'sd18204, c1: 16'sd5366, c2: -16'sd400};
      3'd4:    r = '{c0: 16'sd23170, c1: 16'sd4563, c2: -16'sd488};
      3'd5:    r = '{c0: 16'sd27245, c1: 16'sd3585, c2: -16'sd557};
      3'd6:    r = '{c0: 16'sd30273, c1: 16'sd2469, c2: -16'sd604};
      default: r = '{c0: 16'sd32137, c1: 16'sd1258, c2: -16'sd628};
    endcase
    return r;
  endfunction

  // Product of a constant and an operand, built as a sum of shifted copies.
  function automatic logic signed [PROD_W-1:0] shift_add_mul(
      input logic signed [COEF_W-1:0] c, input logic [OPND_W-1:0] v);
    logic [COEF_W-1:0] mag;
    logic [PROD_W-1:0] acc;
    mag = (c < 0) ? -c : c;
    acc = '0;
    for (int i = 0; i < COEF_W; i++)
      if (mag[i]) acc = acc + (PROD_W'(v) << i);
    return (c < 0) ? -$signed(acc) : $signed(acc);
  endfunction

endpackage

// File: rtl/qlin_ddfs_acc.sv
module qlin_ddfs_acc #(
  parameter int ACC_W = 32,
  parameter int TOP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [ACC_W-1:0] tune_i,
  output logic [TOP_W-1:0] top_o
);
  logic [ACC_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_q <= '0;
    else if (en_i) phase_q <= phase_q + tune_i;
  end

  assign top_o = phase_q[ACC_W-1 -: TOP_W];

  // R1
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(phase_q));

endmodule

// File: rtl/qlin_ddfs_fold.sv
module qlin_ddfs_fold
  import qlin_ddfs_pkg::*;
#(
  parameter int PHASE_W = 14,
  localparam int OFF_W  = PHASE_W - SEG_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic [PHASE_W+1:0]  ph_i,
  output logic                v_o,
  output logic [SEG_BITS-1:0] seg_o,
  output logic [OFF_W-1:0]    off_o,
  output logic                neg_o
);
  logic [PHASE_W-1:0] raw, folded;

  assign raw    = ph_i[PHASE_W-1:0];
  assign folded = ph_i[PHASE_W] ? ~raw : raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o   <= 1'b0;
      seg_o <= '0;
      off_o <= '0;
      neg_o <= 1'b0;
    end else begin
      v_o <= en_i;
      if (en_i) begin
        seg_o <= folded[PHASE_W-1 -: SEG_BITS];
        off_o <= folded[OFF_W-1:0];
        neg_o <= ph_i[PHASE_W+1];
      end
    end
  end

endmodule

// File: rtl/qlin_ddfs_poly.sv
module qlin_ddfs_poly
  import qlin_ddfs_pkg::*;
#(
  parameter int OFF_W = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     v_i,
  input  logic [SEG_BITS-1:0]      seg_i,
  input  logic [OFF_W-1:0]         off_i,
  input  logic                     neg_i,
  output logic                     v_o,
  output logic                     neg_o,
  output logic signed [TERM_W-1:0] base_o,
  output logic signed [TERM_W-1:0] lin_o,
  output logic signed [TERM_W-1:0] quad_o
);
  localparam int NSEG = 1 << SEG_BITS;
  localparam int SQ_W = 2 * OFF_W;

  logic [SQ_W-1:0]          sq;
  logic signed [COEF_W-1:0] base_seg [NSEG];
  logic signed [PROD_W-1:0] lin_seg  [NSEG];
  logic signed [PROD_W-1:0] quad_seg [NSEG];
  logic signed [PROD_W-1:0] lin_sel, quad_sel;

  // the single multiplier: square of the segment offset
  assign sq = off_i * off_i;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam seg_coef_t C = seg_coef(SEG_BITS'(g));
    assign base_seg[g] = C.c0;
    assign lin_seg[g]  = shift_add_mul(C.c1, OPND_W'(off_i));
    assign quad_seg[g] = shift_add_mul(C.c2, OPND_W'(sq));
  end

  assign lin_sel  = lin_seg[seg_i];
  assign quad_sel = quad_seg[seg_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o    <= 1'b0;
      neg_o  <= 1'b0;
      base_o <= '0;
      lin_o  <= '0;
      quad_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        neg_o  <= neg_i;
        base_o <= TERM_W'(base_seg[seg_i]);
        lin_o  <= TERM_W'(lin_sel >>> OFF_W);
        quad_o <= TERM_W'(quad_sel >>> SQ_W);
      end
    end
  end

endmodule

// File: rtl/qlin_ddfs_out.sv
module qlin_ddfs_out
  import qlin_ddfs_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     v_i,
  input  logic                     neg_i,
  input  logic signed [TERM_W-1:0] base_i,
  input  logic signed [TERM_W-1:0] lin_i,
  input  logic signed [TERM_W-1:0] quad_i,
  output logic                     valid_o,
  output logic [OUT_W-1:0]         sample_o
);
  localparam int MAXV = (1 << (OUT_W - 1)) - 1;

  logic signed [TERM_W-1:0] sum;
  logic [OUT_W-1:0]         mag, signed_val;

  always_comb begin
    sum = base_i + lin_i + quad_i;
    if (sum < 0)                     mag = '0;
    else if (sum > TERM_W'(MAXV))    mag = OUT_W'(MAXV);
    else                             mag = sum[OUT_W-1:0];
    signed_val = neg_i ? (~mag + 1'b1) : mag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      sample_o <= '0;
    end else begin
      valid_o <= v_i;
      if (v_i) sample_o <= signed_val;
    end
  end

  // R8
  no_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (sample_o != {1'b1, {(OUT_W-1){1'b0}}}));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v_i |=> $stable(sample_o));

  // R5
  sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_i && neg_i) |=> ($signed(sample_o) <= 0));

endmodule

// File: rtl/qlin_ddfs.sv
module qlin_ddfs
  import qlin_ddfs_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 14,
  parameter int OUT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [ACC_W-1:0] tune_i,
  output logic [OUT_W-1:0] sample_o,
  output logic             valid_o
);
  localparam int OFF_W = PHASE_W - SEG_BITS;
  localparam int TOP_W = PHASE_W + 2;

  logic [TOP_W-1:0]         ph_top;
  logic                     f_v, f_neg, p_v, p_neg;
  logic [SEG_BITS-1:0]      f_seg;
  logic [OFF_W-1:0]         f_off;
  logic signed [TERM_W-1:0] p_base, p_lin, p_quad;

  qlin_ddfs_acc #(.ACC_W(ACC_W), .TOP_W(TOP_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .tune_i(tune_i), .top_o(ph_top));

  qlin_ddfs_fold #(.PHASE_W(PHASE_W)) u_fold (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .ph_i(ph_top),
    .v_o(f_v), .seg_o(f_seg), .off_o(f_off), .neg_o(f_neg));

  qlin_ddfs_poly #(.OFF_W(OFF_W)) u_poly (
    .clk(clk), .rst_n(rst_n), .v_i(f_v), .seg_i(f_seg), .off_i(f_off),
    .neg_i(f_neg), .v_o(p_v), .neg_o(p_neg),
    .base_o(p_base), .lin_o(p_lin), .quad_o(p_quad));

  qlin_ddfs_out #(.OUT_W(OUT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .v_i(p_v), .neg_i(p_neg),
    .base_i(p_base), .lin_i(p_lin), .quad_i(p_quad),
    .valid_o(valid_o), .sample_o(sample_o));

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> ##3 valid_o);

  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> ##3 !valid_o);

endmodule

// File: tb/qlin_ddfs_bench.sv
module qlin_ddfs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] tw = '0;
  logic [15:0] sample;
  logic        valid;

  int checks = 0;
  int failures = 0;
  int prev_s = 0;

  always #5 clk = ~clk;

  qlin_ddfs u_qlin_ddfs (.clk(clk), .rst_n(rst_n), .en_i(en), .tune_i(tw),
                         .sample_o(sample), .valid_o(valid));

  // timing model from R1/R2: phase register plus three-deep delay
  logic [31:0] m_phase, m_p1, m_p2, m_p3;
  logic        m_v1, m_v2, m_v3;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= '0; m_p1 <= '0; m_p2 <= '0; m_p3 <= '0;
      m_v1 <= 1'b0; m_v2 <= 1'b0; m_v3 <= 1'b0;
    end else begin
      if (en) m_phase <= m_phase + tw;
      m_v1 <= en;   m_p1 <= m_phase;
      m_v2 <= m_v1; m_p2 <= m_p1;
      m_v3 <= m_v2; m_p3 <= m_p2;
    end
  end

  function automatic real ref_amp(input logic [31:0] p);
    return 32767.0 * $sin(2.0 * 3.141592653589793 * real'(p) / 4294967296.0);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_near(input logic [31:0] p, input int s, input string tag);
    real r, d;
    r = ref_amp(p);
    d = real'(s) - r;
    if (d < 0.0) d = -d;
    check(d <= 48.0, tag, s, $rtoi(r));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 1'b0; tw = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    prev_s = 0;
  endtask

  // bring the phase to p with one enabled step, then hold it and read the sample
  task automatic sample_at(input logic [31:0] p, output int s);
    do_reset();
    en = 1'b1; tw = p;
    @(negedge clk);
    tw = '0;
    repeat (6) @(negedge clk);
    s = $signed(sample);
  endtask

  task automatic cmp_cycle(input string tag);
    check(valid == m_v3, {"R2 valid ", tag}, int'(valid), int'(m_v3));
    if (m_v3) check_near(m_p3, $signed(sample), {"R4 stream ", tag});
    else      check($signed(sample) == prev_s, {"R9 hold ", tag}, $signed(sample), prev_s);
    prev_s = $signed(sample);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check(valid == 1'b0, "R3 valid after reset", int'(valid), 0);
    check(sample == 16'd0, "R3 sample after reset", $signed(sample), 0);
    en = 1'b1; tw = 32'h1357_9BDF;
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(valid == 1'b0, "R3 valid in reset", int'(valid), 0);
    check(sample == 16'd0, "R3 sample in reset", $signed(sample), 0);
    en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(valid == 1'b0, "R3 pipeline cleared", int'(valid), 0);
  endtask

  task automatic t_latency();
    do_reset();
    en = 1'b1; tw = 32'h0100_0000;
    @(negedge clk); check(valid == 1'b0, "R2 edge1", int'(valid), 0);
    @(negedge clk); check(valid == 1'b0, "R2 edge2", int'(valid), 0);
    @(negedge clk); check(valid == 1'b1, "R2 edge3", int'(valid), 1);
    check(sample == 16'd0, "R8 phase zero sample", $signed(sample), 0);
    en = 1'b0;
    @(negedge clk); check(valid == 1'b1, "R2 edge4", int'(valid), 1);
    en = 1'b1;
    @(negedge clk); check(valid == 1'b1, "R2 edge5", int'(valid), 1);
    @(negedge clk); check(valid == 1'b0, "R2 gap after disabled edge", int'(valid), 0);
    @(negedge clk); check(valid == 1'b1, "R2 edge7", int'(valid), 1);
    check_near(32'h0300_0000, $signed(sample), "R1 phase held over disabled edge");
  endtask

  task automatic t_stream(input logic [31:0] step, input int n, input string tag);
    do_reset();
    en = 1'b1; tw = step;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp_cycle(tag);
    end
  endtask

  task automatic t_pause();
    do_reset();
    en = 1'b1; tw = 32'h0765_4321;
    for (int i = 0; i < 40; i++) begin
      en = ((i % 7) != 3) && ((i % 11) != 5);
      @(negedge clk);
      cmp_cycle("R1 pause pattern");
    end
  endtask

  task automatic t_symmetry();
    int a, b;
    logic [31:0] pv [4] = '{32'h1234_5678, 32'h4000_0000, 32'h7FFF_FFFF, 32'h0000_0000};
    logic [13:0] kv [6] = '{14'd0, 14'd1, 14'd2047, 14'd2048, 14'd9000, 14'd16383};
    foreach (pv[i]) begin
      sample_at(pv[i], a);
      sample_at(pv[i] | 32'h8000_0000, b);
      check(b == -a, "R5 half period negation", b, -a);
    end
    foreach (kv[i]) begin
      sample_at({2'b01, kv[i], 16'h0000}, a);
      sample_at({2'b00, ~kv[i], 16'h0000}, b);
      check(a == b, "R6 quarter mirror", a, b);
    end
    sample_at({16'h2AAA, 16'h0000}, a);
    sample_at({16'h2AAA, 16'hFFFF}, b);
    check(a == b, "R7 low phase bits ignored", b, a);
  endtask

  task automatic t_bounds();
    int s;
    sample_at(32'h0000_0000, s);
    check(s == 0, "R8 zero phase", s, 0);
    sample_at(32'h4000_0000, s);
    check(s >= 32719 && s <= 32767, "R8 positive peak", s, 32767);
    sample_at(32'hC000_0000, s);
    check(s <= -32719 && s >= -32767, "R8 negative peak", s, -32767);
    for (int q = 0; q < 4; q++)
      for (int g = 0; g < 8; g++) begin
        logic [31:0] p;
        p = {2'(q), 14'(g * 2048), 16'h8000};
        sample_at(p, s);
        check_near(p, s, "R4 segment start");
        p = {2'(q), 14'(g * 2048 + 2047), 16'h8000};
        sample_at(p, s);
        check_near(p, s, "R4 segment end");
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_stream(32'h1000_0000, 40, "power of two step");
    t_stream(32'h0123_4567, 300, "irregular step");
    t_stream(32'hF080_0001, 60, "wrapping step");
    t_pause();
    t_symmetry();
    t_bounds();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule